// File: doc/BRIEF.md
# Transfer Completion Interrupt Controller

This block gathers transfer-complete indications from one or more channel completion ports and folds them into one interrupt line. Every completion arrives with an interrupt-request option bit and a 6-bit completion code. When the option bit is set, the code picks one bit of a 64-bit pending register and sets it. Because the code is programmed with the transfer and is not tied to the channel number, several channels can share one code. One channel can also use different codes for different transfers. The interrupt service routine reads the pending register and uses the code to decide what to do.

A 64-bit enable register masks the pending bits. The interrupt output is a registered OR of all pending bits whose enable bit is set. Software reaches the block through a simple register port with a write side and a combinational read side. That port gives write-one-to-clear access to the pending bits. It also gives direct, write-one-to-set and write-one-to-clear access to the enable bits.

Top module: `cmpl_irq_top`

## Requirements
- R1: A completion with its valid bit and its interrupt-request bit both 1 sets pending bit number `code` (0..63) at the next clock edge.
- R2: A completion whose interrupt-request bit is 0 leaves every pending bit unchanged.
- R3: Completions on different ports in the same cycle each set their own pending bit, whether their codes differ or match.
- R4: A write to address 1 clears every pending bit whose write-data bit is 1 and leaves the other pending bits unchanged.
- R5: When a completion sets a pending bit in the same cycle that an address-1 write clears it, the bit ends up set.
- R6: A write to address 2 loads the whole enable register. Reading address 0 returns the pending register. Reading address 2, 3 or 4 returns the enable register. Reading any other address returns zero.
- R7: A write to address 3 sets the enable bits where the write data has a 1, and a write to address 4 clears them. Enable bits where the data has a 0 keep their value.
- R8: The interrupt output in each cycle equals the OR over all bits of (pending AND enable) as they stood one cycle earlier. It therefore falls one cycle after the last enabled pending bit clears.
- R9: After reset, the pending register, the enable register and the interrupt output are all zero.
- R10: A write to address 0 has no effect on the pending register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| cmplValid | input | NUM_PORTS | One completion indication per port, per cycle |
| cmplIntEn | input | NUM_PORTS | Interrupt-request option bit of each completion |
| cmplCode | input | NUM_PORTS*CODE_W | Completion code of each port; port p uses bits [p*CODE_W +: CODE_W] |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register write address |
| wrData | input | NUM_CODES | Register write data |
| rdAddr | input | 3 | Register read address |
| rdData | output | NUM_CODES | Combinational read data for rdAddr |
| irqOut | output | 1 | Registered global interrupt |

## Verification
The bench targets the cases where two sources touch one pending bit in the same cycle. It drives a completion together with a clear of the same bit, so a design that lets the clear win loses that interrupt. It drives two ports together, with different codes and with the same code, so a design that keeps only one port drops a bit. It drives a completion with the request bit low, so a design that ignores that bit raises a spurious pending bit. It follows the interrupt output cycle by cycle as enables and clears change, so an output that is not registered, or that ignores the mask, shows up a cycle early or fires while masked. Writes to the pending address and sweeps of codes across the whole 0..63 range catch decoders that alias or drop high codes.

// File: rtl/cmpl_irq_pkg.sv
package cmpl_irq_pkg;

  localparam int ADDR_W = 3;

  // register addresses; the numbering is what software decodes
  localparam logic [ADDR_W-1:0] ADDR_PEND = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_PCLR = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_EN   = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_ESET = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_ECLR = 3'd4;

  // strobes from control to datapath
  typedef struct packed {
    logic pendClr;
    logic enLoad;
    logic enSet;
    logic enClr;
  } regStrobe_t;

  typedef enum logic [1:0] {
    RD_ZERO = 2'd0,
    RD_PEND = 2'd1,
    RD_EN   = 2'd2
  } rdSel_e;

endpackage

// File: rtl/cmpl_irq_ctrl.sv
module cmpl_irq_ctrl
  import cmpl_irq_pkg::*;
(
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [ADDR_W-1:0] rdAddr,
  output regStrobe_t        strobes,
  output rdSel_e            rdSel
);

  always_comb begin
    strobes = '0;
    if (wrEn) begin
      unique case (wrAddr)
        ADDR_PCLR: strobes.pendClr = 1'b1;
        ADDR_EN:   strobes.enLoad  = 1'b1;
        ADDR_ESET: strobes.enSet   = 1'b1;
        ADDR_ECLR: strobes.enClr   = 1'b1;
        default:   strobes = '0; // pending address and unused slots are read-only
      endcase
    end
  end

  always_comb begin
    unique case (rdAddr)
      ADDR_PEND:                   rdSel = RD_PEND;
      ADDR_EN, ADDR_ESET, ADDR_ECLR: rdSel = RD_EN;
      default:                     rdSel = RD_ZERO;
    endcase
  end

endmodule

// File: rtl/cmpl_irq_dp.sv
module cmpl_irq_dp
  import cmpl_irq_pkg::*;
#(
  parameter int NUM_CODES = 64,
  parameter int NUM_PORTS = 2,
  localparam int CODE_W = $clog2(NUM_CODES)
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [NUM_PORTS-1:0]        cmplValid,
  input  logic [NUM_PORTS-1:0]        cmplIntEn,
  input  logic [NUM_PORTS*CODE_W-1:0] cmplCode,
  input  regStrobe_t                  strobes,
  input  rdSel_e                      rdSel,
  input  logic [NUM_CODES-1:0]        wrData,
  output logic [NUM_CODES-1:0]        rdData,
  output logic [NUM_CODES-1:0]        pendQ,
  output logic [NUM_CODES-1:0]        enQ,
  output logic                        irqOut
);

  logic [NUM_CODES-1:0] portMask [NUM_PORTS];
  logic [NUM_CODES-1:0] setMask;
  logic [NUM_CODES-1:0] clrMask;
  logic [NUM_CODES-1:0] pendNext;
  logic [NUM_CODES-1:0] enNext;

  // one decoder per completion port
  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic [CODE_W-1:0] code;
    assign code = cmplCode[p*CODE_W +: CODE_W];
    always_comb begin
      portMask[p] = '0;
      if (cmplValid[p] && cmplIntEn[p]) portMask[p][code] = 1'b1;
    end
  end

  always_comb begin
    setMask = '0;
    for (int p = 0; p < NUM_PORTS; p++) setMask = setMask | portMask[p];
  end

  assign clrMask  = strobes.pendClr ? wrData : '0;
  // a new completion beats a clear of the same bit
  assign pendNext = (pendQ & ~clrMask) | setMask;

  always_comb begin
    enNext = enQ;
    if (strobes.enLoad) enNext = wrData;
    if (strobes.enSet)  enNext = enNext | wrData;
    if (strobes.enClr)  enNext = enNext & ~wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendQ  <= '0;
      enQ    <= '0;
      irqOut <= 1'b0;
    end else begin
      pendQ  <= pendNext;
      enQ    <= enNext;
      irqOut <= |(pendQ & enQ);
    end
  end

  always_comb begin
    unique case (rdSel)
      RD_PEND: rdData = pendQ;
      RD_EN:   rdData = enQ;
      default: rdData = '0;
    endcase
  end

endmodule

// File: rtl/cmpl_irq_top.sv
module cmpl_irq_top
  import cmpl_irq_pkg::*;
#(
  parameter int NUM_CODES = 64,
  parameter int NUM_PORTS = 2,
  localparam int CODE_W = $clog2(NUM_CODES)
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [NUM_PORTS-1:0]        cmplValid,
  input  logic [NUM_PORTS-1:0]        cmplIntEn,
  input  logic [NUM_PORTS*CODE_W-1:0] cmplCode,
  input  logic                        wrEn,
  input  logic [ADDR_W-1:0]           wrAddr,
  input  logic [NUM_CODES-1:0]        wrData,
  input  logic [ADDR_W-1:0]           rdAddr,
  output logic [NUM_CODES-1:0]        rdData,
  output logic                        irqOut
);

  regStrobe_t           strobes;
  rdSel_e               rdSel;
  logic [NUM_CODES-1:0] pendQ;
  logic [NUM_CODES-1:0] enQ;

  cmpl_irq_ctrl u_ctrl (
    .wrEn    (wrEn),
    .wrAddr  (wrAddr),
    .rdAddr  (rdAddr),
    .strobes (strobes),
    .rdSel   (rdSel)
  );

  cmpl_irq_dp #(
    .NUM_CODES (NUM_CODES),
    .NUM_PORTS (NUM_PORTS)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .cmplValid (cmplValid),
    .cmplIntEn (cmplIntEn),
    .cmplCode  (cmplCode),
    .strobes   (strobes),
    .rdSel     (rdSel),
    .wrData    (wrData),
    .rdData    (rdData),
    .pendQ     (pendQ),
    .enQ       (enQ),
    .irqOut    (irqOut)
  );

endmodule

// File: rtl/cmpl_irq_chk.sv
module cmpl_irq_chk
  import cmpl_irq_pkg::*;
#(
  parameter int NUM_CODES = 64,
  parameter int NUM_PORTS = 2,
  localparam int CODE_W = $clog2(NUM_CODES)
) (
  input logic                        clk,
  input logic                        rstN,
  input logic [NUM_PORTS-1:0]        cmplValid,
  input logic [NUM_PORTS-1:0]        cmplIntEn,
  input logic [NUM_PORTS*CODE_W-1:0] cmplCode,
  input logic                        wrEn,
  input logic [ADDR_W-1:0]           wrAddr,
  input logic [NUM_CODES-1:0]        wrData,
  input logic [NUM_CODES-1:0]        pendQ,
  input logic [NUM_CODES-1:0]        enQ,
  input logic                        irqOut
);

  logic anyReq;
  assign anyReq = |(cmplValid & cmplIntEn);

  // R1
  code0_sets_pend_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmplValid[0] && cmplIntEn[0]) |=> pendQ[$past(cmplCode[CODE_W-1:0])]);

  // R2
  no_req_no_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    !anyReq |=> ((pendQ & ~$past(pendQ)) == '0));

  // R4
  clear_drops_bits_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == ADDR_PCLR && !anyReq) |=> ((pendQ & $past(wrData)) == '0));

  // R6
  enable_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == ADDR_EN) |=> (enQ == $past(wrData)));

  // R8
  irq_lag_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (irqOut == $past(|(pendQ & enQ))));

endmodule

bind cmpl_irq_top cmpl_irq_chk #(
  .NUM_CODES (NUM_CODES),
  .NUM_PORTS (NUM_PORTS)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .cmplValid (cmplValid),
  .cmplIntEn (cmplIntEn),
  .cmplCode  (cmplCode),
  .wrEn      (wrEn),
  .wrAddr    (wrAddr),
  .wrData    (wrData),
  .pendQ     (pendQ),
  .enQ       (enQ),
  .irqOut    (irqOut)
);

// File: tb/sim_cmpl_irq_top.sv
module sim_cmpl_irq_top;

  localparam int NC = 64;
  localparam int NP = 2;
  localparam int CW = 6;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [NP-1:0] cmplValid = '0;
  logic [NP-1:0] cmplIntEn = '0;
  logic [NP*CW-1:0] cmplCode = '0;
  logic          wrEn = 1'b0;
  logic [2:0]    wrAddr = '0;
  logic [NC-1:0] wrData = '0;
  logic [2:0]    rdAddr = '0;
  logic [NC-1:0] rdData;
  logic          irqOut;

  always #10 clk = ~clk; // 50 MHz

  cmpl_irq_top #(.NUM_CODES(NC), .NUM_PORTS(NP)) u0 (
    .clk(clk), .rstN(rstN), .cmplValid(cmplValid), .cmplIntEn(cmplIntEn),
    .cmplCode(cmplCode), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .irqOut(irqOut)
  );

  typedef struct {
    logic [NC-1:0] expData;
    logic          expIrq;
    string         tag;
  } item_t;

  item_t q[$];
  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // reference state, updated from the requirements
  logic [NC-1:0] mPend = '0;
  logic [NC-1:0] mEn   = '0;
  logic          mIrq  = 1'b0;

  function automatic logic [NC-1:0] modelRead(logic [2:0] a);
    if (a == 3'd0) return mPend;
    if (a == 3'd2 || a == 3'd3 || a == 3'd4) return mEn;
    return '0;
  endfunction

  // one cycle of stimulus; pushes what the ports must show before this edge
  task automatic cyc(input logic [1:0] v, input logic [1:0] ie,
                     input int c0, input int c1,
                     input logic we, input logic [2:0] wa, input logic [NC-1:0] wd,
                     input logic [2:0] ra, input string tag);
    item_t it;
    logic [NC-1:0] setM;
    logic [NC-1:0] nextEn;
    @(negedge clk);
    cmplValid = v; cmplIntEn = ie;
    cmplCode = {c1[CW-1:0], c0[CW-1:0]};
    wrEn = we; wrAddr = wa; wrData = wd; rdAddr = ra;
    it.expData = modelRead(ra);
    it.expIrq  = mIrq;
    it.tag     = tag;
    q.push_back(it);
    setM = '0;
    if (v[0] && ie[0]) setM[c0] = 1'b1;
    if (v[1] && ie[1]) setM[c1] = 1'b1;
    nextEn = mEn;
    if (we && wa == 3'd2) nextEn = wd;
    if (we && wa == 3'd3) nextEn = mEn | wd;
    if (we && wa == 3'd4) nextEn = mEn & ~wd;
    mIrq  = |(mPend & mEn);
    mPend = (mPend & ~((we && wa == 3'd1) ? wd : '0)) | setM;
    mEn   = nextEn;
  endtask

  task automatic idle(input logic [2:0] ra, input string tag);
    cyc(2'b00, 2'b00, 0, 0, 1'b0, 3'd0, '0, ra, tag);
  endtask

  task automatic wr(input logic [2:0] wa, input logic [NC-1:0] wd, input string tag);
    cyc(2'b00, 2'b00, 0, 0, 1'b1, wa, wd, 3'd0, tag);
  endtask

  // monitor: compares mid low phase, away from the rising edge
  initial begin
    forever begin
      @(negedge clk);
      #5;
      if (rstN && q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        checks++;
        if (rdData !== it.expData) begin
          errors++;
          $display("FAIL %s rdData actual=%h expected=%h", it.tag, rdData, it.expData);
        end
        checks++;
        if (irqOut !== it.expIrq) begin
          errors++;
          $display("FAIL R8 (%s) irqOut actual=%b expected=%b", it.tag, irqOut, it.expIrq);
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired, actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    // R9: reset values seen directly while reset is held
    @(negedge clk);
    checks++;
    if (irqOut !== 1'b0) begin errors++; $display("FAIL R9 irq actual=%b expected=0", irqOut); end
    @(negedge clk) rstN = 1'b1;
    idle(3'd0, "R9 pending after reset");
    idle(3'd2, "R9 enable after reset");
    // R1
    cyc(2'b01, 2'b01, 5, 0, 1'b0, 3'd0, '0, 3'd0, "R1 before edge");
    idle(3'd0, "R1 code 5 set");
    // R2
    cyc(2'b01, 2'b00, 9, 0, 1'b0, 3'd0, '0, 3'd0, "R2 before edge");
    idle(3'd0, "R2 no request");
    // R3 different codes, then same code
    cyc(2'b11, 2'b11, 63, 0, 1'b0, 3'd0, '0, 3'd0, "R3 before edge");
    idle(3'd0, "R3 two codes");
    cyc(2'b11, 2'b11, 20, 20, 1'b0, 3'd0, '0, 3'd0, "R3 before edge");
    idle(3'd0, "R3 same code");
    // R6 load and R8 rise one cycle later
    wr(3'd2, (64'd1 << 5) | (64'd1 << 63), "R6 write");
    idle(3'd2, "R6 enable readback");
    idle(3'd3, "R6 enable at set alias R8 rise");
    idle(3'd4, "R6 enable at clear alias");
    idle(3'd1, "R6 clear address reads zero");
    idle(3'd6, "R6 unused address reads zero");
    // R10
    wr(3'd0, '1, "R10 write pending address");
    idle(3'd0, "R10 pending unchanged");
    // R4
    wr(3'd1, (64'd1 << 0) | (64'd1 << 5), "R4 clear");
    idle(3'd0, "R4 bits 0 and 5 cleared");
    // R5
    cyc(2'b10, 2'b10, 0, 63, 1'b1, 3'd1, (64'd1 << 63) | (64'd1 << 20), 3'd0, "R5 before edge");
    idle(3'd0, "R5 set wins");
    // R7
    wr(3'd3, 64'd1 << 20, "R7 set");
    idle(3'd2, "R7 after set");
    wr(3'd4, 64'd1 << 63, "R7 clear");
    idle(3'd2, "R7 after clear");
    // R8 fall after clearing all pending
    wr(3'd1, '1, "R4 clear all");
    idle(3'd0, "R8 fall lag");
    idle(3'd0, "R8 fall done");
    // R1 sweep over the code range, with enables opened
    wr(3'd2, '1, "R6 open all");
    for (int i = 0; i < 64; i += 7) begin
      cyc(2'b10, 2'b10, 0, i, 1'b0, 3'd0, '0, 3'd0, "R1 sweep before edge");
      idle(3'd0, "R1 sweep");
    end
    cyc(2'b01, 2'b01, 63, 0, 1'b0, 3'd0, '0, 3'd0, "R1 sweep before edge");
    idle(3'd0, "R1 code 63");
    wr(3'd1, '1, "R4 final clear");
    idle(3'd0, "R4 all cleared");
    idle(3'd0, "R8 final fall");
    idle(3'd0, "R8 idle");
    @(negedge clk);
    @(negedge clk);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule